// File: doc/BRIEF.md
# Serial-to-Parallel Deserializer with Bit Slip

This block turns a serial bit stream into 4-bit parallel words. It is clocked once per serial bit. A select input picks the stream: either the main serial input or a loopback input used for link self-test. Each bit moves through a 4-bit shift register. On the bit-clock edge that closes a word, the four most recent bits are copied into a parallel output register, and a one-cycle word-valid strobe marks the new word. The earliest bit of the word lands on the lowest output bit.

A free-running 3-bit divider counts bit clocks. It produces a quarter-rate clock and an eighth-rate clock. A wide-mode input stretches the word period from four to eight bit clocks, so that two instances can be chained into an 8-bit converter. The serial output passes the delayed stream on to the higher-order instance.

An asynchronous slip request realigns the word boundary. The request is synchronized and edge-detected. Each rising edge then makes the divider hold for one bit clock, which moves every bit one output position lower. A synchronous reset aligns several instances to each other.

Top module: `deser_slip_top`

## Requirements
- R1: The parallel output holds the four bits sampled at the four bit-clock edges up to and including the load edge. The earliest of them is on `parOut[0]` and the latest on `parOut[3]`.
- R2: When `selLoop` is 1, `loopIn` is the sampled bit and `mainIn` has no effect. When `selLoop` is 0, `mainIn` is the sampled bit and `loopIn` has no effect.
- R3: After reset the divider count starts at 0. It advances by one on each bit clock, modulo 8. `clkDiv4` is bit 1 of that count, so it is low for two bit clocks and then high for two.
- R4: `clkDiv8` is bit 2 of the divider count. It toggles each time `clkDiv4` falls.
- R5: With `wideMode` at 0, a load takes place on the edge where the count's low two bits are 3. With `wideMode` at 1, a load takes place only on the edge where the count is 7.
- R6: `wordValid` is high for exactly the one cycle that follows each load edge. `parOut` changes on no other edge.
- R7: A rising edge of `syncReq` that stays high for at least two bit clocks reaches the divider on the third edge after it was first sampled. On that edge the count holds and no load occurs. All later words therefore shift one bit, from position n to position n-1.
- R8: A `syncReq` held high for many cycles produces a single slip. A new slip needs a new low-to-high transition.
- R9: A synchronous, active-high `rst` clears the divider, the shift register, `parOut`, `wordValid`, `clkDiv4`, `clkDiv8`, `serOut` and the slip synchronizer.
- R10: After each edge, `serOut` equals the serial bit sampled three edges earlier, which is the oldest bit in the shift register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst | input | 1 | Synchronous active-high reset |
| mainIn | input | 1 | Main serial data input |
| loopIn | input | 1 | Loopback serial data input |
| selLoop | input | 1 | 1 selects loopIn, 0 selects mainIn |
| wideMode | input | 1 | 1: load every eighth bit; 0: every fourth |
| syncReq | input | 1 | Asynchronous slip request |
| parOut | output | 4 | Parallel word, earliest bit at index 0 |
| wordValid | output | 1 | One-cycle strobe after each load |
| serOut | output | 1 | Delayed serial stream for cascading |
| clkDiv4 | output | 1 | Quarter-rate clock |
| clkDiv8 | output | 1 | Eighth-rate clock |

## Verification
The bench aims at the following cases:
- A slip request held high for many cycles. A design that slips on level instead of edge would walk the boundary on every cycle.
- A slip that lands on the edge where the word would close. A design that loads anyway would emit a short or duplicated word.
- Switching `wideMode` and `selLoop` in the middle of a word. A wrong mux polarity or a wrong wrap compare shows up at once as mismatched words.
- A reset in the middle of a run. It must restore the low-then-high phase of `clkDiv4`; a divider that is not cleared would break the alignment between instances.

// File: rtl/deser_slip_pkg.sv
package deser_slip_pkg;
  typedef struct packed {
    logic loadWord;
  } ctlStrobe_t;
endpackage

// File: rtl/deser_slip_ctrl.sv
module deser_slip_ctrl
  import deser_slip_pkg::*;
#(
  parameter int WORD_W      = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       wideMode,
  input  logic       syncReq,
  output ctlStrobe_t strobes,
  output logic       clkDiv4,
  output logic       clkDiv8
);
  localparam int CNT_W = $clog2(WORD_W) + 1;

  logic [SYNC_STAGES-1:0] syncFf;
  logic                   syncPrev;
  logic                   slipNow;
  logic [CNT_W-1:0]       cnt;
  logic                   narrowWrap;
  logic                   wideWrap;

  // Synchronizer for the asynchronous slip request, then a rising-edge detect
  always_ff @(posedge clk) begin
    if (rst) begin
      syncFf   <= '0;
      syncPrev <= 1'b0;
    end else begin
      syncFf   <= {syncFf[SYNC_STAGES-2:0], syncReq};
      syncPrev <= syncFf[SYNC_STAGES-1];
    end
  end

  assign slipNow = syncFf[SYNC_STAGES-1] & ~syncPrev;

  // Divider: a slip swallows one count
  always_ff @(posedge clk) begin
    if (rst)           cnt <= '0;
    else if (!slipNow) cnt <= cnt + 1'b1;
  end

  assign narrowWrap       = &cnt[CNT_W-2:0];
  assign wideWrap         = &cnt;
  assign strobes.loadWord = ~slipNow & (wideMode ? wideWrap : narrowWrap);
  assign clkDiv4          = cnt[CNT_W-2];
  assign clkDiv8          = cnt[CNT_W-1];
endmodule

// File: rtl/deser_slip_dpath.sv
module deser_slip_dpath
  import deser_slip_pkg::*;
#(
  parameter int WORD_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mainIn,
  input  logic              loopIn,
  input  logic              selLoop,
  input  ctlStrobe_t        strobes,
  output logic [WORD_W-1:0] parOut,
  output logic              wordValid,
  output logic              serOut
);
  logic              serBit;
  logic [WORD_W-1:0] shReg;
  logic [WORD_W-1:0] shNext;

  assign serBit = selLoop ? loopIn : mainIn;

  // The newest bit enters at the top, so the earliest bit ends up at index 0
  assign shNext[WORD_W-1] = serBit;
  for (genvar i = 0; i < WORD_W - 1; i++) begin : g_shift
    assign shNext[i] = shReg[i+1];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      shReg     <= '0;
      parOut    <= '0;
      wordValid <= 1'b0;
    end else begin
      shReg     <= shNext;
      wordValid <= strobes.loadWord;
      if (strobes.loadWord) parOut <= shNext;
    end
  end

  assign serOut = shReg[0];
endmodule

// File: rtl/deser_slip_top.sv
module deser_slip_top
  import deser_slip_pkg::*;
#(
  parameter int WORD_W      = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mainIn,
  input  logic              loopIn,
  input  logic              selLoop,
  input  logic              wideMode,
  input  logic              syncReq,
  output logic [WORD_W-1:0] parOut,
  output logic              wordValid,
  output logic              serOut,
  output logic              clkDiv4,
  output logic              clkDiv8
);
  ctlStrobe_t strobes;

  deser_slip_ctrl #(.WORD_W(WORD_W), .SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk(clk), .rst(rst), .wideMode(wideMode), .syncReq(syncReq),
    .strobes(strobes), .clkDiv4(clkDiv4), .clkDiv8(clkDiv8)
  );

  deser_slip_dpath #(.WORD_W(WORD_W)) u_dpath (
    .clk(clk), .rst(rst), .mainIn(mainIn), .loopIn(loopIn), .selLoop(selLoop),
    .strobes(strobes), .parOut(parOut), .wordValid(wordValid), .serOut(serOut)
  );
endmodule

// File: rtl/deser_slip_chk.sv
module deser_slip_chk #(
  parameter int WORD_W = 4
) (
  input logic              clk,
  input logic              rst,
  input logic [WORD_W-1:0] parOut,
  input logic              wordValid,
  input logic              clkDiv4,
  input logic              clkDiv8
);
  // R9: one cycle after a reset edge, every output is cleared
  a_r9_reset_clears: assert property (@(posedge clk)
    $past(rst) |-> (parOut == '0 && !wordValid && !clkDiv4 && !clkDiv8));

  // R6: the strobe never lasts two cycles
  a_r6_single_strobe: assert property (@(posedge clk) disable iff (rst)
    wordValid |=> !wordValid);

  // R6: the parallel word moves only together with the strobe
  a_r6_word_stable: assert property (@(posedge clk) disable iff (rst)
    (!wordValid && $past(!rst)) |-> $stable(parOut));

  // R5: a new word always comes out as the quarter clock restarts low
  a_r5_load_phase: assert property (@(posedge clk) disable iff (rst)
    wordValid |-> !clkDiv4);

  // R4: the eighth-rate clock moves only when the quarter clock falls
  a_r4_div8_on_fall: assert property (@(posedge clk) disable iff (rst)
    (!$stable(clkDiv8) && $past(!rst)) |-> $fell(clkDiv4));
endmodule

bind deser_slip_top deser_slip_chk #(.WORD_W(WORD_W)) u_chk (.*);

// File: tb/sim_deser_slip_top.sv
module sim_deser_slip_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       mainIn = 1'b0, loopIn = 1'b0, selLoop = 1'b0;
  logic       wideMode = 1'b0, syncReq = 1'b0;
  logic [3:0] parOut;
  logic       wordValid, serOut, clkDiv4, clkDiv8;

  int  testCnt = 0;
  int  failCnt = 0;
  int  cycles = 0;
  bit  done = 1'b0;

  // Behavioural reference
  int       mCnt = 0;
  bit [3:0] mPar = '0;
  bit       mValid = 1'b0;
  bit       hist[$];
  bit       reqQ[$];

  always #4 clk = ~clk;

  deser_slip_top u0 (
    .clk(clk), .rst(rst), .mainIn(mainIn), .loopIn(loopIn), .selLoop(selLoop),
    .wideMode(wideMode), .syncReq(syncReq), .parOut(parOut), .wordValid(wordValid),
    .serOut(serOut), .clkDiv4(clkDiv4), .clkDiv8(clkDiv8)
  );

  always @(posedge clk) begin
    if (rst) begin
      mCnt = 0; mPar = '0; mValid = 1'b0;
      hist = '{0, 0, 0, 0};
      reqQ = '{0, 0, 0, 0};
    end else begin
      bit b;
      bit slip;
      bit wrap;
      b = selLoop ? loopIn : mainIn;
      hist.push_back(b);
      if (hist.size() > 16) void'(hist.pop_front());
      reqQ.push_back(syncReq);
      if (reqQ.size() > 8) void'(reqQ.pop_front());
      // request seen two edges ago, absent three edges ago
      slip = reqQ[reqQ.size()-3] && !reqQ[reqQ.size()-4];
      mValid = 1'b0;
      if (!slip) begin
        wrap = wideMode ? (mCnt == 7) : (mCnt % 4 == 3);
        if (wrap) begin
          mValid = 1'b1;
          for (int i = 0; i < 4; i++) mPar[i] = hist[hist.size()-4+i];
        end
        mCnt = (mCnt + 1) % 8;
      end
    end
  end

  task automatic check(input string tag, input int act, input int exp);
    testCnt++;
    if (act != exp) begin
      failCnt++;
      $display("FAIL %s actual=%0d expected=%0d at cycle %0d", tag, act, exp, cycles);
    end
  endtask

  task automatic compareAll();
    check("R1 R2 R5 parOut", int'(parOut), int'(mPar));
    check("R6 wordValid", int'(wordValid), int'(mValid));
    check("R3 R7 clkDiv4", int'(clkDiv4), (mCnt / 2) % 2);
    check("R4 R8 clkDiv8", int'(clkDiv8), mCnt / 4);
    check("R10 serOut", int'(serOut), rst ? 0 : int'(hist[hist.size()-4]));
  endtask

  task automatic step(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      cycles++;
      compareAll();
      mainIn = 1'($urandom);
      loopIn = 1'($urandom);
    end
  endtask

  task automatic slipPulse(input int len);
    syncReq = 1'b1;
    step(len);
    syncReq = 1'b0;
    step(9);
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", testCnt, failCnt);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    if (cycles > 20000 && !done) begin
      failCnt++;
      $display("FAIL watchdog expired");
      finishRun();
    end
  end

  initial begin
    void'($urandom(7));
    step(3);
    rst = 1'b0;
    // R9: state straight after reset
    check("R9 parOut after reset", int'(parOut), 0);
    check("R9 clkDiv4 after reset", int'(clkDiv4), 0);
    check("R9 clkDiv8 after reset", int'(clkDiv8), 0);
    check("R9 serOut after reset", int'(serOut), 0);
    step(40);                    // R1 R3 R4 on the main path
    selLoop = 1'b1; step(37);    // R2 loopback path, switched mid-word
    selLoop = 1'b0; step(30);
    slipPulse(2);                // R7 minimum-width request
    slipPulse(3);
    slipPulse(2);
    syncReq = 1'b1; step(30);    // R8 held high: one slip only
    syncReq = 1'b0; step(10);
    wideMode = 1'b1; step(45);   // R5 eight-bit period
    slipPulse(2);                // R7 in wide mode
    slipPulse(4);
    selLoop = 1'b1; step(21);
    wideMode = 1'b0; step(19);
    rst = 1'b1; step(2);         // R9 mid-run reset
    rst = 1'b0;
    check("R9 clkDiv4 after second reset", int'(clkDiv4), 0);
    check("R9 wordValid after second reset", int'(wordValid), 0);
    step(25);
    finishRun();
  end
endmodule